// File: doc/BRIEF.md
# Transmit Length and FIFO Controller

This block sits between a host register-write port and a bit-serial transmit encoder. The host programs the frame length in two byte-wide registers and pushes payload bytes into a twelve-entry transmit queue. The length counts whole bytes and may add one trailing byte that is only partly sent. The first payload byte written while the block is idle starts the frame. From then on the encoder pulls one bit at a time over a request/response handshake, and the block marks the final bit.

While a frame runs the block pulses a low-water interrupt when the queue drains to three bytes and the frame still owes more bytes than the queue holds, so the host can top it up. It pulses a done interrupt after the final bit. Bytes written to a full queue are dropped and recorded in a sticky overflow flag. If a byte is needed while the queue is empty, the frame is aborted and an underrun flag is set. A separate register gives the modulation pulse length in carrier cycles, where zero selects the protocol default.

Top module: `txq_ctrl`

## Requirements
- R1: The queue holds FIFO_DEPTH (12) bytes. A write to address 0x1F while the queue is full is dropped, and `err_overflow` is then set and stays set until a flush.
- R2: A `cmd_flush` pulse empties the queue, clears `err_overflow` and `err_underrun`, and ends any running frame (`busy` low, and later bit requests get no response).
- R3: The frame length is encoded across two registers. Register 0x1D holds byte-count bits 11..4. In register 0x1E, bits 7..4 hold byte-count bits 3..0, bits 3..1 hold the bit count of a trailing partial byte, and bit 0 flags that the partial byte is present.
- R4: A queue write while idle raises `busy` one edge later when the frame length (whole bytes, plus one if a partial byte with a nonzero bit count is flagged) is nonzero. With a zero frame length the block stays idle.
- R5: Each `bit_req` pulse seen while busy produces `bit_vld` high for one cycle on the next edge, carrying the next bit. Bytes are sent least significant bit first, in queue order.
- R6: The flagged partial byte is the final byte of the frame, and only its low N bits are sent (N = bits 3..1 of 0x1E). A flag with N = 0 adds no byte.
- R7: `bit_last` is high with the final bit of the frame. `irq_done` pulses for one cycle on the edge after that bit, and `busy` is low by then.
- R8: `irq_low` pulses for one cycle, together with the bit whose fetch takes the queue from 4 to 3 bytes, and only when the frame still owes more than 3 bytes after that fetch.
- R9: A bit request that needs a new byte while the queue is empty produces no `bit_vld`. Instead it sets `err_underrun` and drops `busy`.
- R10: Register 0x1C drives `pulse_cycles`. `pulse_dflt` is high exactly when that register is zero. Its reset value is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| cmd_flush | input | 1 | Empty queue, clear errors, abort frame |
| bit_req | input | 1 | Encoder requests the next bit |
| bit_vld | output | 1 | Response bit valid (one cycle) |
| bit_out | output | 1 | Response bit value |
| bit_last | output | 1 | Response bit is the last of the frame |
| busy | output | 1 | Frame in progress |
| irq_low | output | 1 | Low-water interrupt pulse |
| irq_done | output | 1 | End-of-transmit interrupt pulse |
| err_overflow | output | 1 | Sticky dropped-write flag |
| err_underrun | output | 1 | Sticky starvation flag |
| pulse_cycles | output | 8 | Pulse length override in carrier cycles |
| pulse_dflt | output | 1 | Use the protocol default pulse length |

## Verification
The bench builds the block with its defaults: a depth of 12, a low-water mark of 3 and a 12-bit length. A 40-byte ceiling on random frames therefore forces several refill rounds per frame, and each round crosses the 4-to-3 boundary with bytes still owed. Directed frames with lengths of 0, 4 and partial-only, and with a zero-bit partial flag, test the edges of the length decode. One 20-byte frame fed only 13 bytes causes both an overflow and an underrun in a single run.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} txq_state_e;
  localparam int BYTE_W = 8;
  localparam int PART_W = 3;
endpackage

// File: rtl/txq_regs.sv
module txq_regs #(
  parameter int ADDR_W   = 8,
  parameter int LEN_W    = 12,
  parameter logic [ADDR_W-1:0] A_PULSE = 8'h1C,
  parameter logic [ADDR_W-1:0] A_LENH  = 8'h1D,
  parameter logic [ADDR_W-1:0] A_LENL  = 8'h1E,
  parameter logic [ADDR_W-1:0] A_FIFO  = 8'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              fifo_wr,
  output logic [LEN_W-1:0]  len_bytes,
  output logic [2:0]        part_bits,
  output logic [7:0]        pulse_cycles,
  output logic              pulse_dflt
);
  logic [7:0] len_hi, len_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_hi       <= '0;
      len_lo       <= '0;
      pulse_cycles <= '0;
      pulse_dflt   <= 1'b1;
    end else if (wr_en) begin
      if (wr_addr == A_LENH) len_hi <= wr_data;
      if (wr_addr == A_LENL) len_lo <= wr_data;
      if (wr_addr == A_PULSE) begin
        pulse_cycles <= wr_data;
        pulse_dflt   <= (wr_data == 8'd0);
      end
    end
  end

  assign fifo_wr   = wr_en && (wr_addr == A_FIFO);
  assign len_bytes = LEN_W'({len_hi, len_lo[7:4]});
  assign part_bits = len_lo[0] ? len_lo[3:1] : 3'd0;

  // R10
  pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_dflt == (pulse_cycles == 8'd0));
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DEPTH = 12,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr,
  input  logic [W-1:0]     wdata,
  input  logic             rd,
  output logic [W-1:0]     rdata,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             full, do_wr, do_rd;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
  assign do_wr = wr && !full && !flush;
  assign do_rd = rd && !empty && !flush;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= bump(wptr);
      if (do_rd) rptr <= bump(rptr);
      level <= level + LVL_W'(do_wr) - LVL_W'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)  ovf <= 1'b0;
    else if (wr && full) ovf <= 1'b1;
  end

  // R1
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && full && !flush) |=> ovf);
  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LVL_W'(DEPTH));
  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !ovf));
endmodule

// File: rtl/txq_ser.sv
module txq_ser
  import txq_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int DEPTH     = 12,
  parameter int LOW_MARK  = 3,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int LEFT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             start,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic [2:0]       part_bits,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_rdata,
  output logic             fifo_rd,
  input  logic             bit_req,
  output logic             bit_vld,
  output logic             bit_out,
  output logic             bit_last,
  output logic             busy,
  output logic             irq_low,
  output logic             irq_done,
  output logic             err_under
);
  txq_state_e        state;
  logic [LEFT_W-1:0] left, total_units;
  logic [7:0]        sh_reg;
  logic [3:0]        sh_cnt, this_bits;
  logic [2:0]        last_part;
  logic              serve, need_byte, nxt_bit, is_last, low_hit;

  assign busy        = (state == ST_RUN);
  assign total_units = LEFT_W'(len_bytes) + LEFT_W'(part_bits != 3'd0);
  assign serve       = busy && bit_req && !flush;
  assign need_byte   = (sh_cnt == 4'd0);
  assign this_bits   = (left == LEFT_W'(1) && last_part != 3'd0) ? {1'b0, last_part} : 4'd8;
  assign fifo_rd     = serve && need_byte && !fifo_empty;
  assign nxt_bit     = need_byte ? fifo_rdata[0] : sh_reg[0];
  assign is_last     = need_byte ? (left == LEFT_W'(1) && this_bits == 4'd1)
                                 : (left == '0 && sh_cnt == 4'd1);
  assign low_hit     = fifo_rd && (fifo_level == LVL_W'(LOW_MARK + 1))
                       && (left > LEFT_W'(LOW_MARK + 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; left <= '0; sh_reg <= '0; sh_cnt <= '0; last_part <= '0;
      bit_vld <= 1'b0; bit_out <= 1'b0; bit_last <= 1'b0;
      irq_low <= 1'b0; irq_done <= 1'b0; err_under <= 1'b0;
    end else begin
      bit_vld  <= 1'b0;
      irq_low  <= 1'b0;
      irq_done <= bit_vld && bit_last;
      if (flush) begin
        state <= ST_IDLE; left <= '0; sh_cnt <= '0; err_under <= 1'b0;
      end else if (!busy) begin
        if (start && total_units != '0) begin
          state     <= ST_RUN;
          left      <= total_units;
          last_part <= part_bits;
          sh_cnt    <= '0;
        end
      end else if (serve) begin
        if (need_byte && fifo_empty) begin
          err_under <= 1'b1;
          state     <= ST_IDLE;
        end else begin
          bit_vld  <= 1'b1;
          bit_out  <= nxt_bit;
          bit_last <= is_last;
          irq_low  <= low_hit;
          if (need_byte) begin
            sh_reg <= fifo_rdata >> 1;
            sh_cnt <= this_bits - 4'd1;
            left   <= left - 1'b1;
          end else begin
            sh_reg <= sh_reg >> 1;
            sh_cnt <= sh_cnt - 4'd1;
          end
          if (is_last) state <= ST_IDLE;
        end
      end
    end
  end

  // R5
  vld_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    bit_vld |-> $past(bit_req));
  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> ($past(bit_vld && bit_last) && !busy));
  // R9
  under_stops_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err_under) |-> (!busy && !bit_vld));
  // R8
  low_with_bit_chk: assert property (@(posedge clk) disable iff (rst)
    irq_low |-> bit_vld);
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int DEPTH    = 12,
  parameter int LEN_W    = 12,
  parameter int LOW_MARK = 3,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       cmd_flush,
  input  logic       bit_req,
  output logic       bit_vld,
  output logic       bit_out,
  output logic       bit_last,
  output logic       busy,
  output logic       irq_low,
  output logic       irq_done,
  output logic       err_overflow,
  output logic       err_underrun,
  output logic [7:0] pulse_cycles,
  output logic       pulse_dflt
);
  logic             fifo_wr, fifo_rd, fifo_empty;
  logic [LEN_W-1:0] len_bytes;
  logic [2:0]       part_bits;
  logic [7:0]       fifo_rdata;
  logic [LVL_W-1:0] fifo_level;

  txq_regs #(.ADDR_W(8), .LEN_W(LEN_W)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .fifo_wr, .len_bytes, .part_bits, .pulse_cycles, .pulse_dflt
  );

  txq_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk, .rst, .flush(cmd_flush), .wr(fifo_wr), .wdata(wr_data),
    .rd(fifo_rd), .rdata(fifo_rdata), .level(fifo_level),
    .empty(fifo_empty), .ovf(err_overflow)
  );

  txq_ser #(.LEN_W(LEN_W), .DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_ser (
    .clk, .rst, .flush(cmd_flush), .start(fifo_wr),
    .len_bytes, .part_bits, .fifo_level, .fifo_empty, .fifo_rdata, .fifo_rd,
    .bit_req, .bit_vld, .bit_out, .bit_last, .busy,
    .irq_low, .irq_done, .err_under(err_underrun)
  );
endmodule

// File: tb/txq_ctrl_tb.sv
module txq_ctrl_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, wr_en, cmd_flush, bit_req;
  logic [7:0] wr_addr, wr_data, pulse_cycles;
  logic bit_vld, bit_out, bit_last, busy, irq_low, irq_done;
  logic err_overflow, err_underrun, pulse_dflt;
  int checks = 0, fails = 0;
  logic [7:0] q [0:63];
  logic s_vld, s_out, s_last, s_low, s_done;

  txq_ctrl u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk); cmd_flush = 1'b1;
    @(negedge clk); cmd_flush = 1'b0;
  endtask

  // R3 encoding: 0x1D = count[11:4]; 0x1E = {count[3:0], nbits[2:0], flag}
  task automatic set_len(input int nb, input bit pf, input int nbits);
    logic [11:0] c; logic [2:0] n;
    c = 12'(nb); n = 3'(nbits);
    wreg(8'h1D, c[11:4]);
    wreg(8'h1E, {c[3:0], n, pf});
  endtask

  task automatic req_bit();
    @(negedge clk); bit_req = 1'b1;
    @(posedge clk); #1;
    s_vld = bit_vld; s_out = bit_out; s_last = bit_last; s_low = irq_low;
    @(negedge clk); bit_req = 1'b0;
    @(posedge clk); #1; s_done = irq_done;
  endtask

  task automatic run_frame(input int nb, input bit pf, input int nbits);
    int units, written, popped, level, bits, lb;
    units = nb + ((pf && nbits != 0) ? 1 : 0);
    for (int i = 0; i < units; i++) q[i] = 8'($urandom);
    flush();
    set_len(nb, pf, nbits);
    written = 0; popped = 0; level = 0;
    while (level < 12 && written < units) begin
      wreg(8'h1F, q[written]); written++; level++;
      if (written == 1) chk("R4 busy after first write", busy, 1);
    end
    for (int u = 0; u < units; u++) begin
      bits = (u == units - 1 && pf && nbits != 0) ? nbits : 8;
      for (int j = 0; j < bits; j++) begin
        bit exp_low;
        exp_low = 1'b0;
        if (j == 0) begin
          if (level <= 3)
            while (level < 12 && written < units) begin
              wreg(8'h1F, q[written]); written++; level++;
            end
          lb = level; level--; popped++;
          exp_low = (lb == 4) && (units - popped > 3);
        end
        req_bit();
        chk("R5 bit valid", s_vld, 1);
        chk((u == units - 1 && bits < 8) ? "R6 partial bit value" : "R5 bit value LSB first",
            s_out, int'(q[u][j]));
        chk("R7 last marker", s_last, (u == units - 1 && j == bits - 1) ? 1 : 0);
        chk("R8 low-water pulse", s_low, exp_low ? 1 : 0);
      end
    end
    chk("R7 done pulse", s_done, 1);
    chk("R7 busy clear at end", busy, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; wr_en = 1'b0; cmd_flush = 1'b0; bit_req = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R7 reset busy", busy, 0);
    chk("R1 reset overflow", err_overflow, 0);
    chk("R9 reset underrun", err_underrun, 0);
    chk("R10 reset pulse default", pulse_dflt, 1);

    // R10 pulse length override
    wreg(8'h1C, 8'd5);
    chk("R10 pulse cycles", pulse_cycles, 5);
    chk("R10 default off", pulse_dflt, 0);
    wreg(8'h1C, 8'd0);
    chk("R10 default on for zero", pulse_dflt, 1);

    // R4 zero length stays idle; R6 flag with zero bits adds nothing
    flush(); set_len(0, 0, 0); wreg(8'h1F, 8'hA5);
    chk("R4 zero length idle", busy, 0);
    flush(); set_len(0, 1, 0); wreg(8'h1F, 8'hA5);
    chk("R6 zero-bit partial idle", busy, 0);

    // R6 partial-only frame, R3 partial field
    run_frame(0, 1'b1, 3);
    // exactly four bytes: crossing with nothing owed, no R8 pulse
    run_frame(4, 1'b0, 0);
    // R3 upper nibbles exercised by a count above 15
    run_frame(37, 1'b1, 7);

    // R1 overflow and R9 underrun in one frame
    flush(); set_len(20, 0, 0);
    for (int i = 0; i < 13; i++) begin
      q[i] = 8'(i * 37 + 1);
      wreg(8'h1F, q[i]);
    end
    chk("R1 overflow flag", err_overflow, 1);
    chk("R4 busy", busy, 1);
    for (int u = 0; u < 12; u++)
      for (int j = 0; j < 8; j++) begin
        req_bit();
        chk("R1 kept byte bit", s_out, int'(q[u][j]));
        if (j == 0) chk("R8 pulse on overflow frame", s_low, (u == 8) ? 1 : 0);
      end
    req_bit();
    chk("R9 no valid on starvation", s_vld, 0);
    chk("R9 underrun flag", err_underrun, 1);
    chk("R9 busy dropped", busy, 0);
    chk("R1 overflow still set", err_overflow, 1);
    flush();
    chk("R2 flush clears overflow", err_overflow, 0);
    chk("R2 flush clears underrun", err_underrun, 0);

    // R2 flush mid-frame
    set_len(6, 0, 0);
    wreg(8'h1F, 8'h3C); wreg(8'h1F, 8'h5A);
    req_bit(); req_bit();
    flush();
    chk("R2 flush ends frame", busy, 0);
    req_bit();
    chk("R2 no response after flush", s_vld, 0);

    // random frames
    for (int f = 0; f < 8; f++)
      run_frame($urandom_range(1, 40), 1'($urandom), $urandom_range(0, 7));

    finish_run();
  end
endmodule